// File: doc/BRIEF.md
# Synchronous Multi-Channel PWM Controller

This block generates four pulse-width-modulated outputs. Each channel has a clock prescaler, a period, a left- or center-aligned counting mode and a duty value. Any subset of the channels can join one synchronous group. Members of the group run from the channel 0 counter, take its prescaler, period and alignment, and start and stop with channel 0.

New period and duty values are double-buffered. Software writes them into update registers. A free-running channel copies its own buffered values at each of its own period ends. The group copies its buffered values only at a channel 0 period end. There are two update modes. In mode 0 a software unlock bit releases both period and duty values. In mode 1 the unlock bit releases only the period, and the duty values move on their own after a programmable number of periods.

Software drives the block through a single-cycle write port. The address splits into a 2-bit bank field at the top and a 2-bit index at the bottom. The block outputs the waveforms and a vector that shows which channels are enabled.

Top module: `pwm_sync_group`

## Requirements
- R1: Address `{bank,idx}` with bank 0 is the control bank: idx 0 is enable (each set data bit sets that channel's enable), idx 1 is disable (each set data bit clears it), idx 2 is the group word, idx 3 is the trigger. `ch_active` shows the enable bits, and all of them are 0 after reset.
- R2: Bank 1 idx c sets channel c's prescaler (bits 3:0, tick every pre+1 clocks) and alignment (bit 8, 1 = center). In left-aligned mode the counter runs 0..P, where P is the active period. The waveform repeats every (pre+1)*(P+1) clocks and is high for (pre+1)*min(D,P+1) of them, where D is the active duty.
- R3: In center-aligned mode the counter runs up 0..P and then back down, and a period ends when it returns to 0. The waveform repeats every (pre+1)*2P clocks and is high while the counter is below D. That gives (pre+1)*(min(D,P+1)+max(0,min(D-1,P-1))) high clocks.
- R4: Group word bits 3:0 are the per-channel sync bits. If any of them is set, channel 0 joins the group. A member other than channel 0 compares its duty against the channel 0 counter, and its own prescaler, alignment and period writes have no effect on its output.
- R5: An enable write with bit 0 set enables channel 0 and every group member. A disable write with bit 0 set disables all of them.
- R6: An enable or disable write whose bit for member x (x not 0) is set, with bit 0 clear, changes only channel x.
- R7: A channel's sync bit takes the written value only while that channel is disabled. While the channel is enabled, the write leaves the bit unchanged.
- R8: Group word bit 8 selects the update mode. Banks 2 and 3 idx c hold the buffered period and duty of channel c. In mode 0 the group copies channel 0's buffered period and all members' buffered duties at the first channel 0 period end after trigger bit 0 has been written as 1. Without that write, nothing is copied.
- R9: The unlock bit clears itself at the period end where its copy takes place.
- R10: In mode 1 the group period is copied only on unlock. The update counter (group word bits 19:16) is held at 0 in mode 0. In mode 1, at each group period end, a counter value of 0 copies the member duties and reloads the counter from the field. Any other value decrements it.
- R11: A channel outside the group runs its own counter and copies its own buffered period and duty at each of its own period ends, with no unlock needed.
- R12: A disabled channel drives its output low and holds its counter at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address {bank, index} |
| wr_data | input | 32 | Write data |
| pwm_out | output | 4 | One waveform per channel |
| ch_active | output | 4 | Enable state of each channel |

## Verification
A write is captured on the rising edge where `wr_en` is high. Enable state, sync bits and unlock therefore show one cycle later, and the bench reads `ch_active` on the next falling edge. Each output is combinational on counter and duty flops, so a buffered value appears in the waveform only after the next period end of the counter that drives it. In mode 1 it can take up to the update count plus two periods. The bench waits a settle window several periods longer than that before measuring. It then counts high cycles over a window that is a whole number of periods, so the count does not depend on where the window starts in the period. Group alignment is checked cycle by cycle, by comparing a member's output with channel 0's output when both have the same duty.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  typedef enum logic [1:0] {
    BANK_CTRL = 2'd0,
    BANK_CFG  = 2'd1,
    BANK_PRD  = 2'd2,
    BANK_DTY  = 2'd3
  } bank_e;

  typedef enum logic [1:0] {
    CT_EN   = 2'd0,
    CT_DIS  = 2'd1,
    CT_GRP  = 2'd2,
    CT_TRIG = 2'd3
  } ctl_e;

  localparam int DATA_W      = 32;
  localparam int GRP_MODE_B  = 8;
  localparam int GRP_UPR_LSB = 16;
  localparam int CFG_CTR_B   = 8;

  // true when this tick finishes a period
  function automatic logic cycle_end(input logic [31:0] cnt, input logic [31:0] prd,
                                     input logic ctr, input logic down);
    if (!ctr) return cnt >= prd;
    return (prd == 32'd0) || ((down || cnt >= prd) && cnt <= 32'd1);
  endfunction

  // counter value after one tick
  function automatic logic [31:0] count_step(input logic [31:0] cnt, input logic [31:0] prd,
                                             input logic ctr, input logic down);
    logic gd;
    gd = down || (cnt >= prd);
    if (!ctr) return (cnt >= prd) ? 32'd0 : cnt + 32'd1;
    if (prd == 32'd0) return 32'd0;
    if (gd) return (cnt == 32'd0) ? 32'd0 : cnt - 32'd1;
    return cnt + 32'd1;
  endfunction

  // direction after one tick (1 = counting down)
  function automatic logic next_down(input logic [31:0] cnt, input logic [31:0] prd,
                                     input logic ctr, input logic down);
    logic gd;
    gd = down || (cnt >= prd);
    if (!ctr || prd == 32'd0) return 1'b0;
    return gd && (cnt > 32'd1);
  endfunction

endpackage

// File: rtl/spwm_timebase.sv
module spwm_timebase #(
  parameter int CW = 16,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] pre,
  input  logic          ctr,
  input  logic [CW-1:0] prd,
  output logic [CW-1:0] cnt,
  output logic          bnd
);
  logic [PW-1:0] pdiv;
  logic          down;
  logic          tick;
  logic [31:0]   c32;
  logic [31:0]   p32;

  assign c32  = 32'(cnt);
  assign p32  = 32'(prd);
  assign tick = run && (pdiv >= pre);
  assign bnd  = tick && spwm_pkg::cycle_end(c32, p32, ctr, down);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pdiv <= '0;
      down <= 1'b0;
      cnt  <= '0;
    end else if (tick) begin
      pdiv <= '0;
      cnt  <= CW'(spwm_pkg::count_step(c32, p32, ctr, down));
      down <= spwm_pkg::next_down(c32, p32, ctr, down);
    end else begin
      pdiv <= pdiv + 1'b1;
    end
  end
endmodule

// File: rtl/spwm_regs.sv
module spwm_regs #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int PW  = 4,
  parameter int UW  = 4,
  parameter int CI  = 2,
  parameter int AW  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [31:0]              wr_data,
  output logic [NCH-1:0]           chen,
  output logic [NCH-1:0]           sync_raw,
  output logic [NCH-1:0]           sync_eff,
  output logic                     mode,
  output logic [UW-1:0]            upr,
  output logic [NCH-1:0][PW-1:0]   pre,
  output logic [NCH-1:0]           ctr,
  output logic [NCH-1:0][CW-1:0]   prd_upd,
  output logic [NCH-1:0][CW-1:0]   dty_upd,
  output logic                     unlock_req
);
  import spwm_pkg::*;

  bank_e          bank;
  ctl_e           creg;
  logic [CI-1:0]  idx;
  logic           idx_ok;
  logic [NCH-1:0] dbits;
  logic [NCH-1:0] grp_mask;

  assign bank     = bank_e'(wr_addr[AW-1 -: 2]);
  assign creg     = ctl_e'(wr_addr[1:0]);
  assign idx      = wr_addr[CI-1:0];
  assign idx_ok   = 32'(idx) < NCH;
  assign dbits    = wr_data[NCH-1:0];
  assign sync_eff = {sync_raw[NCH-1:1], |sync_raw};
  assign grp_mask = dbits[0] ? sync_eff : '0;
  assign unlock_req = wr_en && bank == BANK_CTRL && creg == CT_TRIG && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chen     <= '0;
      sync_raw <= '0;
      mode     <= 1'b0;
      upr      <= '0;
      pre      <= '0;
      ctr      <= '0;
      prd_upd  <= '0;
      dty_upd  <= '0;
    end else if (wr_en) begin
      case (bank)
        BANK_CTRL: begin
          case (creg)
            CT_EN:  chen <= chen | dbits | grp_mask;
            CT_DIS: chen <= chen & ~(dbits | grp_mask);
            CT_GRP: begin
              sync_raw <= (sync_raw & chen) | (dbits & ~chen);
              mode     <= wr_data[GRP_MODE_B];
              upr      <= wr_data[GRP_UPR_LSB +: UW];
            end
            default: ;
          endcase
        end
        BANK_CFG: if (idx_ok) begin
          pre[idx] <= wr_data[PW-1:0];
          ctr[idx] <= wr_data[CFG_CTR_B];
        end
        BANK_PRD: if (idx_ok) prd_upd[idx] <= wr_data[CW-1:0];
        default:  if (idx_ok) dty_upd[idx] <= wr_data[CW-1:0];
      endcase
    end
  end
endmodule

// File: rtl/spwm_update.sv
module spwm_update #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int UW  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         bnd,
  input  logic [NCH-1:0]         sync_eff,
  input  logic                   mode,
  input  logic [UW-1:0]          upr,
  input  logic [NCH-1:0][CW-1:0] prd_upd,
  input  logic [NCH-1:0][CW-1:0] dty_upd,
  input  logic                   unlock_req,
  output logic [NCH-1:0][CW-1:0] prd_act,
  output logic [NCH-1:0][CW-1:0] dty_act,
  output logic                   unlock_q,
  output logic                   grp_prd_xfer,
  output logic                   grp_dty_xfer
);
  logic          grp_bnd;
  logic [UW-1:0] upcnt;

  assign grp_bnd      = bnd[0] && sync_eff[0];
  assign grp_prd_xfer = grp_bnd && unlock_q;
  assign grp_dty_xfer = mode ? (grp_bnd && upcnt == '0) : grp_prd_xfer;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
      upcnt    <= '0;
    end else begin
      if (unlock_req)        unlock_q <= 1'b1;
      else if (grp_prd_xfer) unlock_q <= 1'b0;
      if (!mode)             upcnt <= '0;
      else if (grp_bnd)      upcnt <= (upcnt == '0) ? upr : upcnt - 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prd_act[c] <= '0;
        dty_act[c] <= '0;
      end else if (sync_eff[c]) begin
        if (grp_dty_xfer)           dty_act[c] <= dty_upd[c];
        if (grp_prd_xfer && c == 0) prd_act[c] <= prd_upd[c];
      end else if (bnd[c]) begin
        prd_act[c] <= prd_upd[c];
        dty_act[c] <= dty_upd[c];
      end
    end
  end
endmodule

// File: rtl/pwm_sync_group.sv
module pwm_sync_group #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int PW  = 4,
  parameter int UW  = 4,
  localparam int CI = (NCH > 4) ? $clog2(NCH) : 2,
  localparam int AW = CI + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [31:0]    wr_data,
  output logic [NCH-1:0] pwm_out,
  output logic [NCH-1:0] ch_active
);
  logic [NCH-1:0]           chen;
  logic [NCH-1:0]           sync_raw;
  logic [NCH-1:0]           sync_eff;
  logic                     mode;
  logic [UW-1:0]            upr;
  logic [NCH-1:0][PW-1:0]   pre;
  logic [NCH-1:0]           ctr;
  logic [NCH-1:0][CW-1:0]   prd_upd;
  logic [NCH-1:0][CW-1:0]   dty_upd;
  logic [NCH-1:0][CW-1:0]   prd_act;
  logic [NCH-1:0][CW-1:0]   dty_act;
  logic [NCH-1:0][CW-1:0]   cnt;
  logic [NCH-1:0]           bnd;
  logic [NCH-1:0]           run;
  logic                     unlock_req;
  logic                     unlock_q;
  logic                     grp_prd_xfer;
  logic                     grp_dty_xfer;
  logic                     bnd0;
  logic [CW-1:0]            cnt0;
  logic [CW-1:0]            prd0;

  assign bnd0 = bnd[0];
  assign cnt0 = cnt[0];
  assign prd0 = prd_act[0];
  assign ch_active = chen;

  spwm_regs #(.NCH(NCH), .CW(CW), .PW(PW), .UW(UW), .CI(CI), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .chen(chen), .sync_raw(sync_raw), .sync_eff(sync_eff), .mode(mode), .upr(upr),
    .pre(pre), .ctr(ctr), .prd_upd(prd_upd), .dty_upd(dty_upd), .unlock_req(unlock_req)
  );

  spwm_update #(.NCH(NCH), .CW(CW), .UW(UW)) u_upd (
    .clk(clk), .rst_n(rst_n), .bnd(bnd), .sync_eff(sync_eff), .mode(mode), .upr(upr),
    .prd_upd(prd_upd), .dty_upd(dty_upd), .unlock_req(unlock_req),
    .prd_act(prd_act), .dty_act(dty_act), .unlock_q(unlock_q),
    .grp_prd_xfer(grp_prd_xfer), .grp_dty_xfer(grp_dty_xfer)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CW-1:0] cmp_cnt;
    if (c == 0) begin : g_lead
      assign run[c] = chen[0] || |(chen & sync_eff);
    end else begin : g_follow
      assign run[c] = chen[c] && !sync_eff[c];
    end
    spwm_timebase #(.CW(CW), .PW(PW)) u_tb (
      .clk(clk), .rst_n(rst_n), .run(run[c]), .pre(pre[c]), .ctr(ctr[c]),
      .prd(prd_act[c]), .cnt(cnt[c]), .bnd(bnd[c])
    );
    assign cmp_cnt    = sync_eff[c] ? cnt[0] : cnt[c];
    assign pwm_out[c] = chen[c] && (cmp_cnt < dty_act[c]);
  end
endmodule

// File: rtl/pwm_sync_group_chk.sv
module pwm_sync_group_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int AW  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [AW-1:0]          wr_addr,
  input logic [31:0]            wr_data,
  input logic [NCH-1:0]         pwm_out,
  input logic [NCH-1:0]         ch_active,
  input logic [NCH-1:0]         sync_raw,
  input logic [NCH-1:0]         sync_eff,
  input logic                   bnd0,
  input logic                   unlock_q,
  input logic                   unlock_req,
  input logic [NCH-1:0][CW-1:0] dty_act,
  input logic [CW-1:0]          prd0,
  input logic [CW-1:0]          cnt0
);
  // R12
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_out & ~ch_active) == '0));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt0 <= prd0);

  // R7
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(spwm_pkg::CT_GRP))
    |=> (((sync_raw ^ $past(sync_raw)) & $past(ch_active)) == '0));

  // R5
  grp_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(spwm_pkg::CT_EN) && wr_data[0])
    |=> ((ch_active & $past(sync_eff)) == $past(sync_eff)));

  // R8
  grp_prd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_eff[0] && !(bnd0 && unlock_q)) |=> $stable(prd0));

  // R10
  dty_at_group_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_eff[1] && !bnd0) |=> $stable(dty_act[1]));

  // R9
  unlock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd0 && sync_eff[0] && unlock_q && !unlock_req) |=> !unlock_q);
endmodule

bind pwm_sync_group pwm_sync_group_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .pwm_out(pwm_out), .ch_active(ch_active), .sync_raw(sync_raw), .sync_eff(sync_eff),
  .bnd0(bnd0), .unlock_q(unlock_q), .unlock_req(unlock_req), .dty_act(dty_act),
  .prd0(prd0), .cnt0(cnt0)
);

// File: tb/sim_pwm_sync_group.sv
module sim_pwm_sync_group;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  pwm_out;
  logic [3:0]  ch_active;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pwm_sync_group u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                     .wr_data(wr_data), .pwm_out(pwm_out), .ch_active(ch_active));

  // rows: channel, prescaler, period, duty, center
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{0, 0, 9, 3, 0},
    '{3, 1, 4, 2, 0},
    '{1, 0, 5, 9, 0},
    '{2, 0, 4, 2, 1},
    '{0, 2, 3, 0, 1},
    '{3, 0, 6, 7, 1}
  };

  function automatic int period_clks(int pre, int prd, int ctr);
    return (pre + 1) * (ctr != 0 ? 2 * prd : prd + 1);
  endfunction

  function automatic int high_clks(int pre, int prd, int dty, int ctr);
    int up_part, dn_part;
    up_part = (dty < prd + 1) ? dty : prd + 1;
    dn_part = (dty - 1 < prd - 1) ? dty - 1 : prd - 1;
    if (dn_part < 0 || ctr == 0) dn_part = 0;
    return (pre + 1) * (up_part + dn_part);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int bank, int idx, int data);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = 4'((bank << 2) | idx);
    wr_data = 32'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic highs(int ch, int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) h++;
    end
  endtask

  initial begin
    int h, t, mism;
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset enable state", int'(ch_active), 0);
    chk("R12 reset outputs low", int'(pwm_out), 0);

    // R2 R3 R11: independent channels, table driven
    for (int v = 0; v < NV; v++) begin
      int c, pr, pd, dt, ce;
      c = VEC[v][0]; pr = VEC[v][1]; pd = VEC[v][2]; dt = VEC[v][3]; ce = VEC[v][4];
      wr(1, c, pr | (ce << 8));
      wr(2, c, pd);
      wr(3, c, dt);
      wr(0, 0, 1 << c);
      chk("R1 enable strobe", int'(ch_active), 1 << c);
      idle(200);
      t = period_clks(pr, pd, ce);
      highs(c, 2 * t, h);
      chk(ce != 0 ? "R3 center high count" : "R2 left high count", h,
          2 * high_clks(pr, pd, dt, ce));
      wr(0, 1, 1 << c);
      chk("R1 disable strobe", int'(ch_active), 0);
    end

    // R4 R5 R8: group of 0,1,2 in mode 0
    wr(0, 2, 4'b0110);
    wr(1, 0, 0);
    wr(2, 0, 7);
    wr(1, 1, 3 | (1 << 8));
    wr(2, 1, 2);
    wr(3, 0, 3);
    wr(3, 1, 3);
    wr(3, 2, 5);
    wr(0, 3, 1);
    wr(0, 0, 1);
    chk("R5 group enable", int'(ch_active), 4'b0111);
    idle(100);
    mism = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (pwm_out[1] != pwm_out[0]) mism++;
    end
    chk("R4 member follows lead counter", mism, 0);
    highs(2, 16, h);
    chk("R4 member uses lead period", h, 10);

    wr(3, 1, 6);
    idle(50);
    highs(1, 16, h);
    chk("R8 no copy without unlock", h, 6);
    wr(0, 3, 1);
    idle(30);
    highs(1, 16, h);
    chk("R8 copy after unlock", h, 12);
    wr(3, 1, 1);
    idle(40);
    highs(1, 16, h);
    chk("R9 unlock self-cleared", h, 12);

    // R6 R12
    wr(0, 1, 4'b0010);
    chk("R6 member disable alone", int'(ch_active), 4'b0101);
    highs(1, 16, h);
    chk("R12 disabled member low", h, 0);
    wr(0, 0, 4'b0010);
    chk("R6 member enable alone", int'(ch_active), 4'b0111);

    // R11 R7
    wr(1, 3, 0);
    wr(2, 3, 3);
    wr(3, 3, 2);
    wr(0, 0, 4'b1000);
    chk("R7 free channel enabled", int'(ch_active), 4'b1111);
    idle(40);
    highs(3, 8, h);
    chk("R11 free channel beside group", h, 4);
    wr(0, 2, 4'b1110);
    wr(0, 1, 1);
    chk("R7 sync write ignored while enabled", int'(ch_active), 4'b1000);

    // R10: mode 1, update count 2
    wr(0, 1, 4'b1000);
    wr(0, 2, 4'b0110 | (1 << 8) | (2 << 16));
    wr(0, 0, 1);
    chk("R10 group restart", int'(ch_active), 4'b0111);
    idle(20);
    wr(3, 2, 2);
    wr(2, 0, 3);
    idle(80);
    highs(2, 16, h);
    chk("R10 duty copied automatically", h, 4);
    highs(0, 16, h);
    chk("R10 period held without unlock", h, 6);
    wr(0, 3, 1);
    idle(40);
    highs(0, 16, h);
    chk("R10 period copied on unlock", h, 12);
    highs(2, 16, h);
    chk("R10 member on new period", h, 8);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule